// File: doc/BRIEF.md
# Two-Step Batch-Normalization Scaler

The block rescales four signed 16-bit activations by four signed 8-bit per-channel factors, narrows each product with its own arithmetic right shift, and clamps the outcome into a window between an upper and a lower bound. Each clamped channel leaves as one byte, and the four bytes form one 32-bit result word. The four activations arrive packed in a 64-bit operand, the factors in a 32-bit operand, and the shifts and bounds in a 32-bit control word.

A one-cycle start pulse hands over the operands. The block then spends two busy cycles on them, two channels per cycle. Channels 0 and 1 are done first, then channels 2 and 3. A one-cycle done pulse follows, and the result word stays on the output until the next operation writes it. Each product is formed from two byte-wide partial products, the upper byte of the activation taken as signed and the lower byte as unsigned, so a single 8x8 multiplier width serves every channel.

Top module: `bnorm_scaler`

## Requirements
- R1: After reset, busy_o and done_o are 0 and result_o is 0.
- R2: Channel k (k = 0..3) takes activation act_i[16k+15:16k] and factor scale_i[8k+7:8k]. Its product equals the signed 16-bit activation times the signed 8-bit factor, formed as (signed upper byte * factor) shifted left by 8, plus (unsigned lower byte * factor).
- R3: The product of channel k is shifted right arithmetically by ctrl_i[12+5k+4:12+5k], an amount from 0 to 31.
- R4: The upper bound is ctrl_i[11:3], read as a 9-bit signed value. A shifted value above the upper bound becomes the upper bound, and this test takes priority over the lower bound.
- R5: The lower bound comes from ctrl_i[2:0]. Code 0 gives 0, and a code c from 1 to 7 gives -(2^c), so the range runs from -2 to -128. A shifted value that is not above the upper bound but is below the lower bound becomes the lower bound.
- R6: The low 8 bits of the clamped value of channel k go to result_o[8k+7:8k]. Channels 0 and 1 are written at the end of the first busy cycle, while bits [31:16] still hold their old value. Channels 2 and 3 are written at the end of the second busy cycle.
- R7: A start pulse accepted while idle makes busy_o high for exactly the next two cycles. done_o is high for one cycle, in the cycle after the second busy cycle, and result_o then holds the full new word.
- R8: A start pulse while busy_o is high is ignored. The running operation finishes with the operands it captured, and no second operation follows.
- R9: While the block is idle, result_o holds its value whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; operands are captured when the block is idle |
| act_i | input | 64 | Four signed 16-bit activations, channel 0 in the low bits |
| scale_i | input | 32 | Four signed 8-bit factors, channel 0 in the low bits |
| ctrl_i | input | 32 | Per-channel shift amounts, upper bound and lower-bound code |
| busy_o | output | 1 | High during the two working cycles |
| done_o | output | 1 | One-cycle pulse when the result word is complete |
| result_o | output | 32 | Four clamped bytes, channel 0 in the low bits |

## Verification
One vector sets the activation's lower byte to 0xFF with a negative factor. A design that multiplies that byte as signed gives a byte off by a large amount. Other vectors use a negative product with a shift that does not divide it evenly, which shows up a logical shift or rounding toward zero. One uses an upper bound below the lower bound, where a design that tests the lower bound first gives a different byte. The bench also samples the word between the two busy cycles, which exposes a swapped channel order. It pulses start mid-operation, where a block that restarts or loads the new operands gives the wrong word or an extra busy period. Random operands, checked against a reference model built on full-width arithmetic, cover the remaining combinations of shift and bound.

// File: rtl/bns_pkg.sv
package bns_pkg;

   // Width of an index or counter that must distinguish n values; never zero.
   function automatic int bns_idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/bns_bounds.sv
module bns_bounds #(
   parameter int HI_W   = 9,
   parameter int CODE_W = 3,
   parameter int VAL_W  = 24
) (
   input  logic [HI_W-1:0]          hi_field_i,
   input  logic [CODE_W-1:0]        lo_code_i,
   output logic signed [VAL_W-1:0]  hi_o,
   output logic signed [VAL_W-1:0]  lo_o
);

   localparam int EXT_W = VAL_W - HI_W;

   generate
      if (HI_W >= VAL_W) begin : g_bad_hi
         $error("bns_bounds: HI_W must be narrower than VAL_W");
      end
      if ((1 << CODE_W) - 1 >= VAL_W - 1) begin : g_bad_code
         $error("bns_bounds: lower-bound code reaches beyond VAL_W");
      end
   endgenerate

   // upper bound: the field is taken as signed and sign-extended
   assign hi_o = {{EXT_W{hi_field_i[HI_W-1]}}, hi_field_i};

   // lower bound: zero, or minus a power of two chosen by the code
   always_comb begin
      lo_o = '0;
      if (lo_code_i != '0) begin
         lo_o = -(VAL_W'(1) << lo_code_i);
      end
   end

   // R5: decoded lower bound is zero or a negative power of two
   always_comb begin
      if (!$isunknown(lo_code_i)) begin
         a_r5_lo_pow2: assert ((lo_code_i == '0) ? (lo_o == '0)
                               : (lo_o[VAL_W-1] && ($countones(-lo_o) == 1)))
            else $error("a_r5_lo_pow2: bad lower bound");
      end
   end

endmodule

// File: rtl/bns_lane.sv
module bns_lane #(
   parameter int ACT_W     = 16,
   parameter int SC_W      = 8,
   parameter int SH_W      = 5,
   parameter int OUT_W     = 8,
   parameter int VAL_W     = ACT_W + SC_W,
   parameter bit SPLIT_MUL = 1'b1
) (
   input  logic [ACT_W-1:0]         act_i,
   input  logic signed [SC_W-1:0]   scale_i,
   input  logic [SH_W-1:0]          shamt_i,
   input  logic signed [VAL_W-1:0]  hi_i,
   input  logic signed [VAL_W-1:0]  lo_i,
   output logic [OUT_W-1:0]         out_o
);

   localparam int HALF_W = ACT_W / 2;
   localparam int HP_W   = HALF_W + SC_W;      // signed upper-byte partial
   localparam int LP_W   = HALF_W + SC_W + 1;  // unsigned lower-byte partial

   generate
      if (ACT_W % 2 != 0) begin : g_bad_act
         $error("bns_lane: ACT_W must be even for the split multiply");
      end
      if (VAL_W < ACT_W + SC_W) begin : g_bad_val
         $error("bns_lane: VAL_W too narrow for the full product");
      end
      if (OUT_W > VAL_W) begin : g_bad_out
         $error("bns_lane: OUT_W wider than VAL_W");
      end
   endgenerate

   logic signed [VAL_W-1:0] prod;
   logic signed [VAL_W-1:0] shifted;
   logic signed [VAL_W-1:0] clamped;

   generate
      if (SPLIT_MUL) begin : g_split
         logic signed [HP_W-1:0]  hi_part;
         logic signed [LP_W-1:0]  lo_part;
         logic signed [VAL_W-1:0] hi_ext;
         logic signed [VAL_W-1:0] lo_ext;
         logic signed [VAL_W-1:0] ref_prod;

         assign hi_part = $signed(act_i[ACT_W-1:HALF_W]) * scale_i;
         assign lo_part = $signed({1'b0, act_i[HALF_W-1:0]}) * scale_i;
         assign hi_ext  = {{(VAL_W-HP_W){hi_part[HP_W-1]}}, hi_part};
         assign lo_ext  = {{(VAL_W-LP_W){lo_part[LP_W-1]}}, lo_part};
         assign prod    = (hi_ext <<< HALF_W) + lo_ext;

         // R2: the two partial products add up to the full signed product
         assign ref_prod = $signed(act_i) * scale_i;
         always_comb begin
            if (!$isunknown({act_i, scale_i})) begin
               a_r2_split_product: assert (prod == ref_prod)
                  else $error("a_r2_split_product: partial sum mismatch");
            end
         end
      end else begin : g_direct
         assign prod = $signed(act_i) * scale_i;
      end
   endgenerate

   assign shifted = prod >>> shamt_i;

   always_comb begin
      if (shifted > hi_i) begin
         clamped = hi_i;
      end else if (shifted < lo_i) begin
         clamped = lo_i;
      end else begin
         clamped = shifted;
      end
   end

   assign out_o = clamped[OUT_W-1:0];

   always_comb begin
      if (!$isunknown({shifted, hi_i, lo_i})) begin
         // R4: nothing leaves the lane above the upper bound
         a_r4_below_upper: assert ((clamped <= hi_i) || (hi_i < lo_i))
            else $error("a_r4_below_upper: clamp exceeded upper bound");
         // R5: nothing leaves the lane below the lower bound
         a_r5_above_lower: assert ((clamped >= lo_i) || (hi_i < lo_i))
            else $error("a_r5_above_lower: clamp below lower bound");
      end
   end

endmodule

// File: rtl/bns_seq.sv
module bns_seq
   import bns_pkg::*;
#(
   parameter int PHASES = 2,
   parameter int PH_W   = bns_idx_w(PHASES)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   output logic            accept_o,
   output logic            busy_o,
   output logic [PH_W-1:0] phase_o,
   output logic            done_o
);

   localparam logic [PH_W-1:0] LAST = PH_W'(PHASES - 1);

   generate
      if (PHASES < 2) begin : g_bad_phases
         $error("bns_seq: at least two phases are required");
      end
   endgenerate

   logic            busy_q;
   logic            done_q;
   logic [PH_W-1:0] ph_q;

   assign accept_o = start_i && !busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         ph_q   <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (start_i) begin
               busy_q <= 1'b1;
               ph_q   <= '0;
            end
         end else if (ph_q == LAST) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            ph_q   <= '0;
         end else begin
            ph_q <= ph_q + PH_W'(1);
         end
      end
   end

   assign busy_o  = busy_q;
   assign phase_o = ph_q;
   assign done_o  = done_q;

   // R7: an accepted start opens the first phase
   a_r7_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
      accept_o |=> (busy_q && (ph_q == '0)))
      else $error("a_r7_accept_starts");

   // R8: a busy block advances phase by phase, start or not
   a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && (ph_q != LAST)) |=> (busy_q && (ph_q == $past(ph_q) + PH_W'(1))))
      else $error("a_r8_no_restart");

   // R7: last phase is followed by done and idle
   a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && (ph_q == LAST)) |=> (done_q && !busy_q))
      else $error("a_r7_done_after_last");

   // R7: done is a single-cycle pulse
   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q)
      else $error("a_r7_done_single");

   // R7: done never appears without a finished last phase
   a_r7_done_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> $past(busy_q && (ph_q == LAST)))
      else $error("a_r7_done_source");

endmodule

// File: rtl/bnorm_scaler.sv
module bnorm_scaler
   import bns_pkg::*;
#(
   parameter int ACT_W     = 16,
   parameter int SC_W      = 8,
   parameter int SH_W      = 5,
   parameter int OUT_W     = 8,
   parameter int LANES     = 4,
   parameter int LPS       = 2,   // channels handled per busy cycle
   parameter int HI_W      = 9,
   parameter int CODE_W    = 3,
   parameter int HI_LSB    = 3,
   parameter int SH_LSB    = 12,
   parameter bit SPLIT_MUL = 1'b1,
   localparam int ACT_BUS  = LANES * ACT_W,
   localparam int SC_BUS   = LANES * SC_W,
   localparam int CTRL_W   = SH_LSB + LANES * SH_W,
   localparam int RES_W    = LANES * OUT_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [ACT_BUS-1:0] act_i,
   input  logic [SC_BUS-1:0]  scale_i,
   input  logic [CTRL_W-1:0]  ctrl_i,
   output logic               busy_o,
   output logic               done_o,
   output logic [RES_W-1:0]   result_o
);

   localparam int PHASES = LANES / LPS;
   localparam int PH_W   = bns_idx_w(PHASES);
   localparam int CH_W   = bns_idx_w(LANES);
   localparam int VAL_W  = ACT_W + SC_W;
   localparam int STEP_W = LPS * OUT_W;

   generate
      if (LANES % LPS != 0) begin : g_bad_split
         $error("bnorm_scaler: LANES must be a multiple of LPS");
      end
      if (PHASES < 2) begin : g_bad_steps
         $error("bnorm_scaler: the work must span at least two cycles");
      end
      if (CODE_W > HI_LSB || HI_LSB + HI_W > SH_LSB) begin : g_bad_fields
         $error("bnorm_scaler: control fields overlap");
      end
   endgenerate

   // ---------------- sequencing ----------------
   logic            accept;
   logic            busy;
   logic            done;
   logic [PH_W-1:0] phase;

   bns_seq #(.PHASES(PHASES), .PH_W(PH_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .accept_o (accept),
      .busy_o   (busy),
      .phase_o  (phase),
      .done_o   (done)
   );

   // ---------------- operand capture ----------------
   logic [ACT_BUS-1:0] act_q;
   logic [SC_BUS-1:0]  sc_q;
   logic [CTRL_W-1:0]  ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= '0;
         sc_q   <= '0;
         ctrl_q <= '0;
      end else if (accept) begin
         act_q  <= act_i;
         sc_q   <= scale_i;
         ctrl_q <= ctrl_i;
      end
   end

   logic [ACT_W-1:0] act_arr [LANES];
   logic [SC_W-1:0]  sc_arr  [LANES];
   logic [SH_W-1:0]  sh_arr  [LANES];

   for (genvar c = 0; c < LANES; c++) begin : g_chan
      assign act_arr[c] = act_q[c*ACT_W +: ACT_W];
      assign sc_arr[c]  = sc_q[c*SC_W +: SC_W];
      assign sh_arr[c]  = ctrl_q[SH_LSB + c*SH_W +: SH_W];
   end

   // ---------------- clamp bounds ----------------
   logic signed [VAL_W-1:0] hi_bound;
   logic signed [VAL_W-1:0] lo_bound;

   bns_bounds #(.HI_W(HI_W), .CODE_W(CODE_W), .VAL_W(VAL_W)) u_bounds (
      .hi_field_i (ctrl_q[HI_LSB +: HI_W]),
      .lo_code_i  (ctrl_q[CODE_W-1:0]),
      .hi_o       (hi_bound),
      .lo_o       (lo_bound)
   );

   // ---------------- shared lane datapaths ----------------
   logic [CH_W-1:0]  lane_ch  [LPS];
   logic [OUT_W-1:0] lane_out [LPS];

   for (genvar i = 0; i < LPS; i++) begin : g_lane
      assign lane_ch[i] = CH_W'(LPS * int'(phase) + i);

      bns_lane #(
         .ACT_W     (ACT_W),
         .SC_W      (SC_W),
         .SH_W      (SH_W),
         .OUT_W     (OUT_W),
         .VAL_W     (VAL_W),
         .SPLIT_MUL (SPLIT_MUL)
      ) u_lane (
         .act_i   (act_arr[lane_ch[i]]),
         .scale_i ($signed(sc_arr[lane_ch[i]])),
         .shamt_i (sh_arr[lane_ch[i]]),
         .hi_i    (hi_bound),
         .lo_i    (lo_bound),
         .out_o   (lane_out[i])
      );
   end

   // ---------------- result assembly ----------------
   logic [OUT_W-1:0] res_arr [LANES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int c = 0; c < LANES; c++) begin
            res_arr[c] <= '0;
         end
      end else if (busy) begin
         for (int i = 0; i < LPS; i++) begin
            res_arr[lane_ch[i]] <= lane_out[i];
         end
      end
   end

   for (genvar c = 0; c < LANES; c++) begin : g_pack
      assign result_o[c*OUT_W +: OUT_W] = res_arr[c];
   end

   assign busy_o = busy;
   assign done_o = done;

   // R9: the result word never moves while idle
   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(result_o))
      else $error("a_r9_idle_hold");

   // R6: first cycle leaves the later channels untouched
   a_r6_first_step_low: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (phase == '0)) |=> $stable(result_o[RES_W-1:STEP_W]))
      else $error("a_r6_first_step_low");

   // R8: captured operands hold through the whole operation
   a_r8_operands_hold: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable({act_q, sc_q, ctrl_q}))
      else $error("a_r8_operands_hold");

endmodule

// File: tb/bnorm_scaler_tb.sv
`timescale 1ns/1ps
module bnorm_scaler_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [63:0] act_i = '0;
   logic [31:0] scale_i = '0;
   logic [31:0] ctrl_i = '0;
   logic        busy_o;
   logic        done_o;
   logic [31:0] result_o;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   bnorm_scaler u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .act_i    (act_i),
      .scale_i  (scale_i),
      .ctrl_i   (ctrl_i),
      .busy_o   (busy_o),
      .done_o   (done_o),
      .result_o (result_o)
   );

   // {act, scale, ctrl, expected}
   localparam int NV = 8;
   localparam logic [159:0] VECS [NV] = '{
      {64'h0064_0064_0064_0064, 32'h0202_0202, 32'h0000_03FF, 32'h7F7F_7F7F}, // R4 saturate high
      {64'hFFFD_0003_FFF6_000A, 32'hFBFB_0303, 32'h0000_03FF, 32'h0FF1_E21E}, // R2 signs
      {64'h03E8_03E8_03E8_03E8, 32'h0101_0101, 32'h5148_33F8, 32'h001F_3E7D}, // R3 per-channel shift
      {64'hFC18_FC18_FC18_FC18, 32'h0101_0101, 32'h18C6_33FE, 32'hC0C0_C0C0}, // R5 code 6
      {64'hFFF9_FFFF_0001_0007, 32'h0101_0101, 32'h0000_0029, 32'hFEFF_0105}, // R4 R5 tight window
      {64'h8000_8000_8000_8000, 32'h8080_8080, 32'h8421_03FF, 32'h4040_4040}, // R2 extremes
      {64'h0005_FFF0_FFEC_0032, 32'h0101_0101, 32'h0000_0F80, 32'hF000_00F0}, // R4 upper wins
      {64'h0000_0000_0000_01FF, 32'h0000_00FF, 32'h0000_23FF, 32'h0000_0080}  // R2 unsigned low byte
   };

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] model(input logic [63:0] a, input logic [31:0] s, input logic [31:0] c);
      logic [31:0] r;
      longint p, v, hi, lo;
      hi = longint'($signed(c[11:3]));
      lo = (c[2:0] == 3'd0) ? 64'sd0 : -(longint'(1) << c[2:0]);
      for (int k = 0; k < 4; k++) begin
         p = longint'($signed(a[k*16 +: 16])) * longint'($signed(s[k*8 +: 8]));
         v = p >>> c[12 + k*5 +: 5];
         if (v > hi) v = hi;
         else if (v < lo) v = lo;
         r[k*8 +: 8] = v[7:0];
      end
      return r;
   endfunction

   // called at a falling edge; returns at a falling edge
   task automatic run_op(input logic [63:0] a, input logic [31:0] s, input logic [31:0] c,
                         input logic [31:0] exp, input string req);
      logic [31:0] prev;
      prev    = result_o;
      act_i   = a;
      scale_i = s;
      ctrl_i  = c;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o === 1'b1 && done_o === 1'b0, "R7 busy in first cycle",
          {30'd0, busy_o, done_o}, 32'd2);
      @(negedge clk);
      chk(busy_o === 1'b1, "R7 busy in second cycle", {31'd0, busy_o}, 32'd1);
      chk(result_o === {prev[31:16], exp[15:0]}, "R6 channels 0 and 1 first",
          result_o, {prev[31:16], exp[15:0]});
      @(negedge clk);
      chk(done_o === 1'b1 && busy_o === 1'b0, "R7 done after two cycles",
          {30'd0, busy_o, done_o}, 32'd1);
      chk(result_o === exp, req, result_o, exp);
      @(negedge clk);
      chk(done_o === 1'b0, "R7 done is one cycle", {31'd0, done_o}, 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] held;
      logic [63:0] ra;
      logic [31:0] rs, rc;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk(busy_o === 1'b0 && done_o === 1'b0, "R1 idle in reset", {30'd0, busy_o, done_o}, 32'd0);
      chk(result_o === 32'd0, "R1 result cleared", result_o, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy_o === 1'b0 && result_o === 32'd0, "R1 idle after reset", result_o, 32'd0);

      // table of vectors
      for (int v = 0; v < NV; v++) begin
         run_op(VECS[v][159:96], VECS[v][95:64], VECS[v][63:32], VECS[v][31:0],
                "R2 R3 R4 R5 table vector");
      end

      // R8: start while busy is ignored
      act_i   = VECS[2][159:96];
      scale_i = VECS[2][95:64];
      ctrl_i  = VECS[2][63:32];
      start_i = 1'b1;
      @(negedge clk);
      act_i   = VECS[3][159:96];
      scale_i = VECS[3][95:64];
      ctrl_i  = VECS[3][63:32];
      @(negedge clk);
      start_i = 1'b0;
      @(negedge clk);
      chk(result_o === VECS[2][31:0], "R8 running operands kept", result_o, VECS[2][31:0]);
      chk(done_o === 1'b1, "R8 operation completes", {31'd0, done_o}, 32'd1);
      @(negedge clk);
      chk(busy_o === 1'b0, "R8 no second operation", {31'd0, busy_o}, 32'd0);
      @(negedge clk);
      chk(busy_o === 1'b0 && result_o === VECS[2][31:0], "R8 still idle", result_o, VECS[2][31:0]);

      // R9: idle hold while inputs change
      held = result_o;
      for (int k = 0; k < 6; k++) begin
         act_i   = {$urandom(), $urandom()};
         scale_i = $urandom();
         ctrl_i  = $urandom();
         @(negedge clk);
      end
      chk(result_o === held && busy_o === 1'b0, "R9 idle result held", result_o, held);

      // random operands against the model
      for (int k = 0; k < 40; k++) begin
         ra = {$urandom(), $urandom()};
         rs = $urandom();
         rc = $urandom();
         run_op(ra, rs, rc, model(ra, rs, rc), "R2 R3 R4 R5 random vector");
      end

      // back-to-back: start in the done cycle
      act_i   = VECS[1][159:96];
      scale_i = VECS[1][95:64];
      ctrl_i  = VECS[1][63:32];
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (2) @(negedge clk);
      chk(done_o === 1'b1 && result_o === VECS[1][31:0], "R7 first of pair", result_o, VECS[1][31:0]);
      run_op(VECS[6][159:96], VECS[6][95:64], VECS[6][63:32], VECS[6][31:0], "R7 start in done cycle");

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule